// File: doc/BRIEF.md
# Indirect Word Read Port

This block lets an 8-bit processor read single 16-bit words out of a large table region that lies outside its own address space. The processor sets a page number and a word offset in small byte-wide registers. It then reads the selected word one byte at a time through two data ports. The block keeps no copy of the data. Every data-port read sends a fresh request to the backing memory, so the value returned always matches what the memory holds at that moment.

By default the pointer does not move when the data ports are read. When a control bit is set, the word offset moves forward by one after each read of the low-byte port. This allows a table to be streamed word by word. The offset wraps inside the current page and never changes the page number.

Bus timing: an access lasts one clock, with `cpu_cs` high for that clock. Read data appears on `cpu_rdata` during the following clock. The memory gets its combined address and read strobe in the access clock and returns its data one clock later.

Top module: `idx_word_port`

## Requirements
- R1: After reset, the page register, both offset bytes and the control register read back as 0.
- R2: Writes to select 0 (page), 1 (offset high byte) and 2 (offset low byte) are read back unchanged. Select 5 is the control register. Only bit 0 (auto-step enable) is stored, and the other bits read as 0.
- R3: A read of select 3 returns the high byte of the addressed word, and a read of select 4 returns the low byte. The memory address is {page, offset, byte}, where byte is 0 for select 3 and 1 for select 4. The memory strobe is raised only for these two reads.
- R4: Every data-port read fetches from memory again. If the memory contents change between two reads of the same port, the second read returns the new value.
- R5: When auto-step is off, reading either data port leaves the offset unchanged.
- R6: When auto-step is on, a read of select 4 adds one to the offset after the access. A read of select 3 never changes the offset.
- R7: An auto-step from a low offset byte of 0xFF carries into the high offset byte.
- R8: An auto-step from offset 0xFFFF wraps to 0x0000 and leaves the page register unchanged.
- R9: Writes to selects 3, 4, 6 and 7 change no register. Reads of selects 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_cs | input | 1 | Access strobe, one clock per access |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_sel | input | 3 | Register select within the port window |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid the clock after a read |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | PAGE_W+OFS_W+1 | {page, word offset, byte select} |
| mem_rdata | input | DATA_W | Memory data, one clock after mem_rd |

## Verification
The bench covers several corner cases, and each one shows a specific kind of error in the design:
- Carry from the low offset byte into the high byte. A missing carry would send the next read to the start of the same 256-word stretch.
- Wrap at the top of the page. An offset adder that spilled into the page register would make the read land in the neighbouring page.
- The memory contents are changed between two identical reads. A design that cached the fetched byte would return the old value.
- A read of the high-byte port with auto-step on. A design that stepped on either port would skip every other word.
- Writes to the data ports and to the unused selects. A decoder that aliased these writes onto a pointer register would corrupt the page or the offset.

// File: rtl/idx_port_pkg.sv
package idx_port_pkg;

   localparam int unsigned SEL_W        = 3;
   localparam int unsigned CTRL_INC_BIT = 0;

   typedef enum logic [SEL_W-1:0] {
      SEL_PAGE   = 3'd0,
      SEL_OFS_HI = 3'd1,
      SEL_OFS_LO = 3'd2,
      SEL_DAT_HI = 3'd3,
      SEL_DAT_LO = 3'd4,
      SEL_CTRL   = 3'd5
   } port_sel_e;

   // one decoded bus access
   typedef struct packed {
      logic wr;      // register write
      logic rd_reg;  // register read (returned from a holding flop)
      logic rd_mem;  // data-port read (returned from memory)
      logic bsel;    // 0 = high byte, 1 = low byte
      logic step;    // candidate for auto-step
   } bus_op_t;

endpackage

// File: rtl/idx_decode.sv
module idx_decode
   import idx_port_pkg::*;
(
   input  logic             cs,
   input  logic             rw,
   input  logic [SEL_W-1:0] sel,
   output bus_op_t          op
);

   always_comb begin
      op = '0;
      if (cs) begin
         if (!rw) begin
            op.wr = 1'b1;
         end else begin
            case (sel)
               SEL_DAT_HI: begin
                  op.rd_mem = 1'b1;
                  op.bsel   = 1'b0;
               end
               SEL_DAT_LO: begin
                  op.rd_mem = 1'b1;
                  op.bsel   = 1'b1;
                  op.step   = 1'b1;
               end
               default: op.rd_reg = 1'b1;
            endcase
         end
      end
   end

endmodule

// File: rtl/idx_regs.sv
module idx_regs
   import idx_port_pkg::*;
#(
   parameter int unsigned PAGE_W  = 8,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned OFS_W   = 16,
   parameter bit          INC_OPT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_op_t           op,
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [PAGE_W-1:0] page_q,
   output logic [OFS_W-1:0]  ofs_q,
   output logic              auto_inc
);

   localparam int unsigned HI_LSB = OFS_W - DATA_W;

   logic wr_page, wr_hi, wr_lo, wr_ctrl;

   assign wr_page = op.wr && (sel == SEL_PAGE);
   assign wr_hi   = op.wr && (sel == SEL_OFS_HI);
   assign wr_lo   = op.wr && (sel == SEL_OFS_LO);
   assign wr_ctrl = op.wr && (sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
      end else if (wr_page) begin
         page_q <= wdata[PAGE_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q <= '0;
      end else if (wr_hi) begin
         ofs_q[OFS_W-1:HI_LSB] <= wdata;
      end else if (wr_lo) begin
         ofs_q[DATA_W-1:0] <= wdata;
      end else if (op.step && auto_inc) begin
         ofs_q <= ofs_q + OFS_W'(1);   // wraps inside the page
      end
   end

   generate
      if (INC_OPT) begin : g_inc
         logic inc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               inc_q <= 1'b0;
            end else if (wr_ctrl) begin
               inc_q <= wdata[CTRL_INC_BIT];
            end
         end
         assign auto_inc = inc_q;
      end else begin : g_no_inc
         logic unused_ctrl;
         assign unused_ctrl = wr_ctrl;
         assign auto_inc    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/idx_rdata.sv
module idx_rdata
   import idx_port_pkg::*;
#(
   parameter int unsigned PAGE_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OFS_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_op_t           op,
   input  logic [SEL_W-1:0]  sel,
   input  logic [PAGE_W-1:0] page_q,
   input  logic [OFS_W-1:0]  ofs_q,
   input  logic              auto_inc,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned HI_LSB = OFS_W - DATA_W;

   logic [DATA_W-1:0] reg_val;
   logic [DATA_W-1:0] reg_q;
   logic              from_mem_q;

   always_comb begin
      reg_val = '0;
      case (sel)
         SEL_PAGE:   reg_val = DATA_W'(page_q);
         SEL_OFS_HI: reg_val = ofs_q[OFS_W-1:HI_LSB];
         SEL_OFS_LO: reg_val = ofs_q[DATA_W-1:0];
         SEL_CTRL:   reg_val[CTRL_INC_BIT] = auto_inc;
         default:    reg_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q      <= '0;
         from_mem_q <= 1'b0;
      end else begin
         from_mem_q <= op.rd_mem;
         if (op.rd_reg) begin
            reg_q <= reg_val;
         end
      end
   end

   // data-port reads pass memory straight through: nothing is held here
   assign rdata = from_mem_q ? mem_rdata : reg_q;

endmodule

// File: rtl/idx_word_port.sv
module idx_word_port
   import idx_port_pkg::*;
#(
   parameter int unsigned PAGE_W  = 8,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned OFS_W   = 16,
   parameter bit          INC_OPT = 1'b1,
   localparam int unsigned MEM_AW = PAGE_W + OFS_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_cs,
   input  logic              cpu_rw,
   input  logic [SEL_W-1:0]  cpu_sel,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_rd,
   output logic [MEM_AW-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata
);

   generate
      if (OFS_W != 2 * DATA_W) begin : g_bad_ofs
         $error("idx_word_port: OFS_W must be two data bytes");
      end
      if (PAGE_W > DATA_W || PAGE_W == 0) begin : g_bad_page
         $error("idx_word_port: PAGE_W must fit one data byte");
      end
   endgenerate

   bus_op_t           op;
   logic [PAGE_W-1:0] page_q;
   logic [OFS_W-1:0]  ofs_q;
   logic              auto_inc;

   idx_decode u_dec (
      .cs  (cpu_cs),
      .rw  (cpu_rw),
      .sel (cpu_sel),
      .op  (op)
   );

   idx_regs #(
      .PAGE_W  (PAGE_W),
      .DATA_W  (DATA_W),
      .OFS_W   (OFS_W),
      .INC_OPT (INC_OPT)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .sel      (cpu_sel),
      .wdata    (cpu_wdata),
      .page_q   (page_q),
      .ofs_q    (ofs_q),
      .auto_inc (auto_inc)
   );

   idx_rdata #(
      .PAGE_W (PAGE_W),
      .DATA_W (DATA_W),
      .OFS_W  (OFS_W)
   ) u_rdata (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .sel       (cpu_sel),
      .page_q    (page_q),
      .ofs_q     (ofs_q),
      .auto_inc  (auto_inc),
      .mem_rdata (mem_rdata),
      .rdata     (cpu_rdata)
   );

   assign mem_rd   = op.rd_mem;
   assign mem_addr = {page_q, ofs_q, op.bsel};

endmodule

// File: rtl/idx_word_port_chk.sv
module idx_word_port_chk
   import idx_port_pkg::*;
#(
   parameter int unsigned PAGE_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OFS_W  = 16,
   localparam int unsigned MEM_AW = PAGE_W + OFS_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_cs,
   input logic              cpu_rw,
   input logic [SEL_W-1:0]  cpu_sel,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              mem_rd,
   input logic [MEM_AW-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              auto_inc
);

   logic rd_hi, rd_lo, wr_page;
   logic [OFS_W-1:0]  ofs_f;
   logic [PAGE_W-1:0] page_f;

   assign rd_hi   = cpu_cs && cpu_rw && (cpu_sel == SEL_DAT_HI);
   assign rd_lo   = cpu_cs && cpu_rw && (cpu_sel == SEL_DAT_LO);
   assign wr_page = cpu_cs && !cpu_rw && (cpu_sel == SEL_PAGE);
   assign ofs_f   = mem_addr[OFS_W:1];
   assign page_f  = mem_addr[MEM_AW-1:OFS_W+1];

   AST_HI_BYTE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi |-> (mem_rd && !mem_addr[0]));                           // R3
   AST_LO_BYTE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |-> (mem_rd && mem_addr[0]));                            // R3
   AST_NO_STRAY_RD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_cs && cpu_rw) |-> !mem_rd);                              // R3
   AST_LIVE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mem_rd) |-> (cpu_rdata == mem_rdata));                   // R4
   AST_HOLD_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && !auto_inc) |=> $stable(ofs_f));                      // R5
   AST_HI_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi |=> $stable(ofs_f));                                     // R6
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && auto_inc) |=> (ofs_f == OFS_W'($past(ofs_f) + 1'b1))); // R7
   AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_page |=> $stable(page_f));                                 // R8

endmodule

bind idx_word_port idx_word_port_chk #(
   .PAGE_W (PAGE_W),
   .DATA_W (DATA_W),
   .OFS_W  (OFS_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_cs    (cpu_cs),
   .cpu_rw    (cpu_rw),
   .cpu_sel   (cpu_sel),
   .cpu_rdata (cpu_rdata),
   .mem_rd    (mem_rd),
   .mem_addr  (mem_addr),
   .mem_rdata (mem_rdata),
   .auto_inc  (u_regs.auto_inc)
);

// File: tb/idx_word_port_tb_top.sv
`timescale 1ns/1ps
module idx_word_port_tb_top;

   localparam int PAGE_W = 8;
   localparam int DATA_W = 8;
   localparam int OFS_W  = 16;
   localparam int MEM_AW = PAGE_W + OFS_W + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_cs = 1'b0;
   logic              cpu_rw = 1'b0;
   logic [2:0]        cpu_sel = '0;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic [DATA_W-1:0] cpu_rdata;
   logic              mem_rd;
   logic [MEM_AW-1:0] mem_addr;
   logic [DATA_W-1:0] mem_q = '0;

   always #4 clk = ~clk;   // 125 MHz

   idx_word_port dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_cs    (cpu_cs),
      .cpu_rw    (cpu_rw),
      .cpu_sel   (cpu_sel),
      .cpu_wdata (cpu_wdata),
      .cpu_rdata (cpu_rdata),
      .mem_rd    (mem_rd),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_q)
   );

   // memory model: contents computed from the address, perturbed by a key
   logic [7:0] mem_key = 8'h00;

   function automatic logic [7:0] mem_fn(input logic [MEM_AW-1:0] a, input logic [7:0] k);
      logic [7:0] r;
      r = a[7:0] + a[15:8] * 8'd3 + a[23:16] * 8'd7 + {7'd0, a[24]} * 8'd11;
      return r ^ k;
   endfunction

   always @(posedge clk) if (mem_rd) mem_q <= mem_fn(mem_addr, mem_key);

   // scoreboard
   int    n_checks = 0;
   int    n_fail   = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       rd_seen = 1'b0;

   always @(posedge clk) rd_seen <= cpu_cs & cpu_rw;

   always @(negedge clk) begin
      if (rd_seen) begin
         logic [7:0] e;
         string      t;
         n_checks++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard empty: actual=%h expected=none", cpu_rdata);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (cpu_rdata !== e) begin
               n_fail++;
               $display("FAIL %s: actual=%h expected=%h", t, cpu_rdata, e);
            end
         end
      end
   end

   // bench-side model of the pointer
   logic [7:0]  m_page = '0;
   logic [15:0] m_ofs  = '0;
   logic        m_inc  = 1'b0;

   task automatic bus_write(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk);
      cpu_cs = 1'b1; cpu_rw = 1'b0; cpu_sel = s; cpu_wdata = d;
      @(negedge clk);
      cpu_cs = 1'b0;
      case (s)
         3'd0: m_page = d;
         3'd1: m_ofs[15:8] = d;
         3'd2: m_ofs[7:0] = d;
         3'd5: m_inc = d[0];
         default: ;
      endcase
   endtask

   task automatic bus_read(input logic [2:0] s, input logic [7:0] e, input string t);
      @(negedge clk);
      cpu_cs = 1'b1; cpu_rw = 1'b1; cpu_sel = s;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      cpu_cs = 1'b0;
   endtask

   task automatic read_word_byte(input logic lo, input string t);
      logic [7:0] e;
      e = mem_fn({m_page, m_ofs, lo}, mem_key);
      bus_read(lo ? 3'd4 : 3'd3, e, t);
      if (lo && m_inc) m_ofs = m_ofs + 16'd1;
   endtask

   task automatic read_ptr(input string t);
      bus_read(3'd0, m_page, t);
      bus_read(3'd1, m_ofs[15:8], t);
      bus_read(3'd2, m_ofs[7:0], t);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      read_ptr("R1 reset pointer");
      bus_read(3'd5, 8'h00, "R1 reset ctrl");

      // R2 register write/readback
      bus_write(3'd0, 8'h3C);
      bus_write(3'd1, 8'h12);
      bus_write(3'd2, 8'h34);
      read_ptr("R2 readback");
      bus_write(3'd5, 8'hFE);
      bus_read(3'd5, 8'h00, "R2 ctrl upper bits");
      bus_write(3'd5, 8'hFF);
      bus_read(3'd5, 8'h01, "R2 ctrl enable bit");
      bus_write(3'd5, 8'h00);

      // R3 byte order and address formation
      read_word_byte(1'b0, "R3 high byte");
      read_word_byte(1'b1, "R3 low byte");
      // R5 default mode does not move the pointer
      read_word_byte(1'b1, "R5 repeat low byte");
      read_ptr("R5 pointer unchanged");

      // R4 live fetch after memory change
      mem_key = 8'hA5;
      read_word_byte(1'b1, "R4 refetch low");
      read_word_byte(1'b0, "R4 refetch high");
      mem_key = 8'h00;

      // R9 writes to data ports and unused selects are ignored
      bus_write(3'd3, 8'hEE);
      bus_write(3'd4, 8'hDD);
      bus_write(3'd6, 8'hCC);
      bus_write(3'd7, 8'hBB);
      read_ptr("R9 pointer after ignored writes");
      bus_read(3'd5, 8'h00, "R9 ctrl after ignored writes");
      bus_read(3'd6, 8'h00, "R9 unused select 6");
      bus_read(3'd7, 8'h00, "R9 unused select 7");

      // R6 auto-step on low byte only
      bus_write(3'd5, 8'h01);
      read_word_byte(1'b0, "R6 high byte read");
      bus_read(3'd2, m_ofs[7:0], "R6 no step after high read");
      read_word_byte(1'b1, "R6 low byte read");
      bus_read(3'd2, m_ofs[7:0], "R6 stepped offset");
      for (int i = 0; i < 6; i++) begin
         read_word_byte(1'b0, "R6 stream high");
         read_word_byte(1'b1, "R6 stream low");
      end

      // R7 carry into the high offset byte
      bus_write(3'd1, 8'h12);
      bus_write(3'd2, 8'hFF);
      read_word_byte(1'b1, "R7 low byte before carry");
      read_ptr("R7 carry");
      read_word_byte(1'b0, "R7 data after carry");

      // R8 wrap at page end, page kept
      bus_write(3'd1, 8'hFF);
      bus_write(3'd2, 8'hFF);
      read_word_byte(1'b1, "R8 last word of page");
      read_ptr("R8 wrap");
      read_word_byte(1'b1, "R8 first word after wrap");

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule